// File: doc/BRIEF.md
# Packet-Gated Threshold FIFO

This block is a synchronous first-in first-out store for 32-bit words that hands data onward only in whole packets. It keeps a count of the words it holds and compares that count with a threshold register that can be loaded at run time. When the count rises past the threshold, the block raises a packet-ready level and a single-cycle transfer-request pulse. On the sending side, the ready level tells a transform engine to take one packet. On the returning side, the pulse starts one DMA read by the host.

Once the first word of a ready packet is taken, the block stops offering further packets. It counts accepted reads until exactly one packet length has left. Only then does it compare the occupancy with the threshold again. The store holds two packets. A writer can therefore fill the next packet while the current one drains, and the drain, the fill and a host read of an earlier result can all overlap.

Pushes into a full store and pops from an empty store are dropped. Either one also sets an error flag that stays set until reset.

Top module: `pkt_thresh_fifo`

## Requirements
- R1: After reset the store is empty (occupancy 0, `empty`=1, `full`=0), `pkt_ready`, `xfer_req`, `draining` and `err_flag` are 0, and the threshold holds 1022.
- R2: Words leave in the order they were written, and `rd_data` always shows the oldest stored word while the store is not empty.
- R3: An accepted push raises `level` by one, an accepted pop lowers it by one, and both in the same cycle leave it unchanged. `full` is 1 exactly when `level` equals DEPTH (2048), and `empty` is 1 exactly when `level` is 0.
- R4: A push while `full` is dropped even if a pop happens in the same cycle. A pop while `empty` is dropped. Either one sets `err_flag`, which then stays 1 until reset.
- R5: While the block is waiting, if `level` is strictly greater than the threshold at a clock edge, `pkt_ready` is 1 from that edge on.
- R6: `xfer_req` is 1 for exactly one cycle, the first cycle in which `pkt_ready` is 1, so there is one pulse per packet offered.
- R7: The first accepted pop while `pkt_ready` is 1 drops `pkt_ready` and raises `draining`. `draining` stays 1 until PKT_WORDS (1024) pops have been accepted, counting that first one. The block then waits and compares again at the next edge. Pops while waiting are not counted.
- R8: A cycle with `thr_load`=1 stores `thr_value` as the threshold, and the new value is used from the next edge.
- R9: Writes are accepted while a packet drains. A second packet written concurrently with the drain is kept whole and is offered, with its own pulse, right after the first drain ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Push request |
| wr_data | input | 32 | Word to push |
| rd_en | input | 1 | Pop request |
| rd_data | output | 32 | Oldest stored word |
| thr_load | input | 1 | Load enable for the threshold |
| thr_value | input | 12 | New threshold value |
| level | output | 12 | Current occupancy |
| full | output | 1 | Occupancy equals depth |
| empty | output | 1 | Occupancy is zero |
| pkt_ready | output | 1 | A packet is offered to the consumer |
| xfer_req | output | 1 | One-cycle transfer request per offered packet |
| draining | output | 1 | A packet drain is in progress |
| err_flag | output | 1 | Sticky overflow/underflow error |

## Verification
The bench compares occupancy, flags and head data against a queue model on every cycle. It uses these input patterns:
- A short mixed pattern of pushes, pops and simultaneous push/pop separates correct count arithmetic from an off-by-one on concurrent access.
- A back-to-back packet fill followed by a drain overlapped with the next fill shows whether the gate counts exactly one packet length, re-arms once, and pulses once per packet.
- A lowered threshold with a fill that stops exactly at the threshold and then one word beyond it tells a strict comparison from an inclusive one.
- Pops on an empty store and a push past full exercise the drop and sticky-error paths.

// File: rtl/pf_pkg.sv
package pf_pkg;

  // Packet gate states
  typedef enum logic [1:0] {
    GATE_WAIT  = 2'd0,
    GATE_READY = 2'd1,
    GATE_DRAIN = 2'd2
  } gate_st_t;

  // Occupancy after one cycle of accepted push/pop
  function automatic int unsigned lvl_step(input int unsigned lvl,
                                           input logic push,
                                           input logic pop);
    case ({push, pop})
      2'b10:   return lvl + 1;
      2'b01:   return lvl - 1;
      default: return lvl;
    endcase
  endfunction

  // Strictly above the watermark
  function automatic logic over_thr(input int unsigned lvl,
                                    input int unsigned thr);
    return lvl > thr;
  endfunction

endpackage

// File: rtl/pf_store.sv
module pf_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_ok,
  input  logic          pop_ok,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam bit POW2 = (DEPTH == (1 << AW));

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q, wptr_n, rptr_n;

  // Pointer advance: natural wrap for power-of-two depth, explicit otherwise
  generate
    if (POW2) begin : g_wrap_nat
      assign wptr_n = wptr_q + 1'b1;
      assign rptr_n = rptr_q + 1'b1;
    end else begin : g_wrap_cmp
      assign wptr_n = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      assign rptr_n = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (push_ok) wptr_q <= wptr_n;
      if (pop_ok)  rptr_q <= rptr_n;
    end
  end

  // Show-ahead head word
  assign rd_data = mem[rptr_q];

endmodule

// File: rtl/pf_level.sv
module pf_level #(
  parameter int DEPTH = 2048,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          err_flag
);
  logic [LW-1:0] level_q, level_d;
  logic          err_q;
  logic          drop_push, drop_pop;

  assign full      = (level_q == LW'(DEPTH));
  assign empty     = (level_q == '0);
  assign push_ok   = wr_en && !full;
  assign pop_ok    = rd_en && !empty;
  assign drop_push = wr_en && full;
  assign drop_pop  = rd_en && empty;
  assign level_d   = LW'(pf_pkg::lvl_step(32'(level_q), push_ok, pop_ok));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= '0;
      err_q   <= 1'b0;
    end else begin
      level_q <= level_d;
      err_q   <= err_q | drop_push | drop_pop;
    end
  end

  assign level    = level_q;
  assign err_flag = err_q;

  // R3: occupancy never exceeds the depth
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LW'(DEPTH));
  // R4: push into a full store with no pop leaves the count alone
  a_r4_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en) |=> $stable(level_q));
  // R4: the error flag never clears outside reset
  a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R4: a dropped access raises the error flag on the next cycle
  a_r4_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_push || drop_pop) |=> err_q);

endmodule

// File: rtl/pf_gate.sv
module pf_gate #(
  parameter int PKT_WORDS  = 1024,
  parameter int LW         = 12,
  parameter int THRESH_RST = 1022
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] level,
  input  logic          pop_ok,
  input  logic          thr_load,
  input  logic [LW-1:0] thr_value,
  output logic          pkt_ready,
  output logic          xfer_req,
  output logic          draining
);
  import pf_pkg::*;

  localparam int CW = (PKT_WORDS > 1) ? $clog2(PKT_WORDS) : 1;

  gate_st_t      st_q, st_d;
  logic [LW-1:0] thr_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          req_q;

  // Named events for assertions
  logic above_thr, arm_evt, drain_start, pkt_done;

  assign above_thr   = over_thr(32'(level), 32'(thr_q));
  assign arm_evt     = (st_q == GATE_WAIT) && above_thr;
  assign drain_start = (st_q == GATE_READY) && pop_ok;
  assign pkt_done    = (st_q == GATE_DRAIN) && pop_ok && (cnt_q == CW'(PKT_WORDS - 1));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      GATE_WAIT: begin
        if (arm_evt) st_d = GATE_READY;
      end
      GATE_READY: begin
        if (drain_start) begin
          st_d  = GATE_DRAIN;
          cnt_d = CW'(1);
        end
      end
      GATE_DRAIN: begin
        if (pkt_done) begin
          st_d  = GATE_WAIT;
          cnt_d = '0;
        end else if (pop_ok) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = GATE_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= GATE_WAIT;
      cnt_q <= '0;
      req_q <= 1'b0;
      thr_q <= LW'(THRESH_RST);
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      req_q <= arm_evt;
      if (thr_load) thr_q <= thr_value;
    end
  end

  assign pkt_ready = (st_q == GATE_READY);
  assign draining  = (st_q == GATE_DRAIN);
  assign xfer_req  = req_q;

  // R5: ready only rises after the count was above the watermark
  a_r5_ready_after_cross: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_ready) |-> $past(above_thr));
  // R6: request is a single-cycle pulse
  a_r6_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |=> !xfer_req);
  // R6: request coincides with the packet being offered
  a_r6_req_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> pkt_ready);
  // R7: taking the first word stops the offer and starts the drain
  a_r7_drain_entry: assert property (@(posedge clk) disable iff (!rst_n)
    drain_start |=> (!pkt_ready && draining));
  // R7: no re-offer while a drain is in progress
  a_r7_no_ready_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (draining && !pkt_done) |=> !pkt_ready);

endmodule

// File: rtl/pkt_thresh_fifo.sv
module pkt_thresh_fifo #(
  parameter int DW         = 32,
  parameter int PKT_WORDS  = 1024,
  parameter int DEPTH      = 2048,
  parameter int THRESH_RST = 1022,
  parameter int LW         = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          thr_load,
  input  logic [LW-1:0] thr_value,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          pkt_ready,
  output logic          xfer_req,
  output logic          draining,
  output logic          err_flag
);
  logic push_ok, pop_ok;

  pf_level #(.DEPTH(DEPTH), .LW(LW)) u_level (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .push_ok(push_ok), .pop_ok(pop_ok), .level(level),
    .full(full), .empty(empty), .err_flag(err_flag)
  );

  pf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push_ok(push_ok), .pop_ok(pop_ok),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  pf_gate #(.PKT_WORDS(PKT_WORDS), .LW(LW), .THRESH_RST(THRESH_RST)) u_gate (
    .clk(clk), .rst_n(rst_n), .level(level), .pop_ok(pop_ok),
    .thr_load(thr_load), .thr_value(thr_value),
    .pkt_ready(pkt_ready), .xfer_req(xfer_req), .draining(draining)
  );

  // R2: a pop never happens on an empty store
  a_r2_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |-> !empty);

endmodule

// File: tb/tb_pkt_thresh_fifo.sv
module tb_pkt_thresh_fifo;
  localparam int DW = 32;
  localparam int PKT = 1024;
  localparam int DEPTH = 2048;
  localparam int LW = 12;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, thr_load = 0;
  logic [DW-1:0] wr_data = '0;
  logic [LW-1:0] thr_value = '0;
  logic [DW-1:0] rd_data;
  logic [LW-1:0] level;
  logic full, empty, pkt_ready, xfer_req, draining, err_flag;

  always #4 clk = ~clk;

  pkt_thresh_fifo dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .thr_load(thr_load), .thr_value(thr_value), .level(level),
    .full(full), .empty(empty), .pkt_ready(pkt_ready), .xfer_req(xfer_req),
    .draining(draining), .err_flag(err_flag)
  );

  int errors = 0, checks = 0, pulses = 0, cyc = 0;
  int unsigned dseq = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [DW-1:0] q[$];
  int m_st = 0, m_cnt = 0, m_thr = 1022;
  bit m_req = 0, m_err = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_st = 0; m_cnt = 0; m_thr = 1022; m_req = 0; m_err = 0;
    end else begin
      bit push_ok, pop_ok;
      int occ;
      occ = q.size();
      push_ok = wr_en && (occ < DEPTH);
      pop_ok  = rd_en && (occ > 0);
      m_req = 0;
      if (m_st == 0) begin
        if (occ > m_thr) begin m_st = 1; m_req = 1; end
      end else if (m_st == 1) begin
        if (pop_ok) begin m_st = 2; m_cnt = 1; end
      end else begin
        if (pop_ok) begin
          if (m_cnt == PKT - 1) begin m_st = 0; m_cnt = 0; end
          else m_cnt++;
        end
      end
      if (thr_load) m_thr = thr_value;
      if ((wr_en && !push_ok) || (rd_en && !pop_ok)) m_err = 1;
      if (pop_ok) void'(q.pop_front());
      if (push_ok) q.push_back(wr_data);
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (xfer_req) pulses++;
      chk(level == LW'(q.size()), "R3 level", level, q.size());
      chk(full == (q.size() == DEPTH), "R3 full", full, q.size() == DEPTH);
      chk(empty == (q.size() == 0), "R3 empty", empty, q.size() == 0);
      if (q.size() > 0) chk(rd_data == q[0], "R2 head word", rd_data, q[0]);
      chk(err_flag == m_err, "R4 err_flag", err_flag, m_err);
      chk(pkt_ready == (m_st == 1), "R5 pkt_ready", pkt_ready, m_st == 1);
      chk(xfer_req == m_req, "R6 xfer_req", xfer_req, m_req);
      chk(draining == (m_st == 2), "R7 draining", draining, m_st == 2);
      if (cyc == 150000) begin
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  task automatic push_n(input int n);
    for (int i = 0; i < n; i++) begin
      wr_en = 1; wr_data = 32'hA500_0000 + dseq; dseq++;
      @(negedge clk);
    end
    wr_en = 0;
  endtask

  task automatic pop_n(input int n);
    for (int i = 0; i < n; i++) begin
      rd_en = 1;
      @(negedge clk);
    end
    rd_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; wr_en = 0; rd_en = 0; thr_load = 0;
    idle(3);
    rst_n = 1;
    idle(1);
  endtask

  initial begin
    idle(1);
    do_reset();
    // R1: reset state
    chk(level == 0 && empty && !full, "R1 empty after reset", level, 0);
    chk(!pkt_ready && !xfer_req && !draining && !err_flag, "R1 flags low",
        {pkt_ready, xfer_req, draining, err_flag}, 0);

    // R2/R3: mixed push, simultaneous push/pop, pop
    push_n(5);
    wr_en = 1; rd_en = 1; wr_data = 32'hA500_0000 + dseq; dseq++;
    idle(1);
    wr_en = 0; rd_en = 0;
    pop_n(2);
    chk(level == 3, "R3 concurrent push/pop count", level, 3);

    // R4: pop on empty sets sticky error
    pop_n(4);
    chk(err_flag == 1 && level == 0, "R4 underflow dropped", err_flag, 1);
    push_n(1);
    chk(err_flag == 1 && level == 1, "R4 err stays set", err_flag, 1);
    do_reset();
    chk(err_flag == 0 && level == 0, "R1 reset clears error", err_flag, 0);

    // R5/R6: one packet at default threshold 1022
    pulses = 0;
    push_n(1022);
    idle(2);
    chk(!pkt_ready, "R5 not ready at threshold", pkt_ready, 0);
    push_n(2);
    idle(2);
    chk(pkt_ready == 1, "R5 ready above threshold", pkt_ready, 1);
    chk(pulses == 1, "R6 one pulse", pulses, 1);

    // R7/R9: drain overlapped with the next packet fill
    for (int i = 0; i < PKT; i++) begin
      wr_en = 1; rd_en = 1; wr_data = 32'hA500_0000 + dseq; dseq++;
      @(negedge clk);
      if (i == 500) begin
        chk(draining && !pkt_ready, "R7 draining mid packet", draining, 1);
        chk(pulses == 1, "R6 no pulse during drain", pulses, 1);
      end
    end
    wr_en = 0; rd_en = 0;
    idle(3);
    chk(level == 1024 && !err_flag, "R9 second packet kept whole", level, 1024);
    chk(pulses == 2, "R9 second packet offered", pulses, 2);
    pop_n(PKT);
    idle(2);
    chk(level == 0 && !draining && !pkt_ready, "R7 drain complete", draining, 0);

    // R7: pops while waiting are not counted
    push_n(3);
    pop_n(3);
    chk(!draining && !pkt_ready, "R7 waiting pops ignored by gate", draining, 0);

    // R8: threshold load
    thr_load = 1; thr_value = 12'd10;
    idle(1);
    thr_load = 0;
    pulses = 0;
    push_n(10);
    idle(3);
    chk(!pkt_ready, "R8 not ready at new threshold", pkt_ready, 0);
    push_n(1);
    idle(2);
    chk(pkt_ready && pulses == 1, "R8 ready above new threshold", pulses, 1);
    push_n(PKT - 11);
    pop_n(PKT);
    idle(2);
    chk(level == 0 && !draining, "R7 packet drained", level, 0);

    // R3/R4: fill past full
    push_n(DEPTH + 1);
    idle(2);
    chk(full && level == LW'(DEPTH), "R3 full at depth", level, DEPTH);
    chk(err_flag == 1, "R4 overflow dropped", err_flag, 1);

    idle(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule